// File: doc/BRIEF.md
# Pre-trigger sample capture controller

This block stores one parallel sample word on every clock into an on-chip dual-port ring buffer. All channels share a single capture edge. Arming starts the writer at address zero, and the writer then moves one location per stored word. While the block is armed, the buffer keeps overwriting itself, so it always holds the newest history. A trigger is accepted only once a programmed amount of history has been written. The triggering sample and the samples after it then fill the rest of the ring. When the ring holds exactly one full window, writing stops and a done flag is raised.

The block reports two addresses: the address where the triggering sample landed and the address of the oldest sample in the window. A reader on the second memory port can fetch any address at any time, including while the writer is running. The buffer depth must be a power of two. The programmed history length must be less than the depth, and the width of the length port enforces this.

Top module: `pretrig_capture`

## Requirements
- R1: After reset, `armed`, `triggered`, `done` and `rd_valid` are 0, and `wr_addr`, `trig_addr` and `win_start` are 0.
- R2: An `arm` pulse, in any state, moves the block to armed on the next edge with `wr_addr` = 0 and `done` = 0. The cycle in which `arm` is high writes nothing.
- R3: While armed or triggered, each clock stores `sample_in` at `wr_addr`, and `wr_addr` then advances by one modulo DEPTH (DEPTH-1 wraps to 0).
- R4: While armed, `trig_in` has no effect until at least `pre_len` samples have been stored since arming. With `pre_len` = 0, a trigger is accepted in the first armed cycle.
- R5: When a trigger is accepted, `trig_addr` takes the address written in that same cycle, and `triggered` rises on the next edge. `triggered` rises only after an armed cycle with `trig_in` high.
- R6: Counting the trigger sample, exactly DEPTH − `pre_len` samples are stored after the trigger, and then `done` rises. When `pre_len` = DEPTH−1, `done` follows the trigger directly. No writes occur while idle or done, and `trig_in` is ignored in both of those states. At most one of `armed`, `triggered` and `done` is high at a time.
- R7: `win_start` = (`trig_addr` − `pre_len`) mod DEPTH. When `done` rises, `wr_addr` equals `win_start`.
- R8: `rd_en` with `rd_addr` returns that entry on `rd_data` one cycle later with `rd_valid` = 1. Reads work during acquisition. A read of the address being written in the same cycle returns the old contents. `rd_data` holds its value when `rd_en` is low.
- R9: `pre_len` is sampled only on the `arm` cycle. Changing it later has no effect on the running capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | Restart capture (synchronous) |
| pre_len | input | AW | History length, sampled at arm |
| sample_in | input | W | Parallel sample word from all channels |
| trig_in | input | 1 | Trigger event |
| rd_en | input | 1 | Read request on second port |
| rd_addr | input | AW | Read address |
| rd_data | output | W | Read data, one cycle after request |
| rd_valid | output | 1 | rd_data updated this cycle |
| wr_addr | output | AW | Next write address |
| armed | output | 1 | Waiting for trigger, filling history |
| triggered | output | 1 | Storing post-trigger samples |
| done | output | 1 | Window complete, writing stopped |
| trig_addr | output | AW | Address of trigger sample |
| win_start | output | AW | Address of oldest window sample |

## Verification
The assertions assume four things about the inputs. DEPTH is a power of two. `arm` and `trig_in` are known two-state values after reset. `pre_len` is always below DEPTH. A reader treats `rd_data` as meaningful only in cycles where `rd_valid` is high. The stimulus changes inputs only on the falling clock edge. It draws `pre_len` values from the full range of the 4-bit port, including 0 and DEPTH−1, so the length limit always holds. It also re-arms both mid-window and after completion, so every state transition that the window-closing and trigger-source properties rely on is reached.

// File: rtl/pcap_pkg.sv
package pcap_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_POST  = 2'd2,
    ST_DONE  = 2'd3
  } cap_state_t;
endpackage

// File: rtl/pcap_ram.sv
module pcap_ram #(
  parameter int W     = 16,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data,
  output logic          rd_valid
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  // read port: nonblocking read gives old data on a same-address write
  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_valid <= 1'b0;
    else        rd_valid <= rd_en;
  end

  // R8: data register is held when no read is requested
  a_r8_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
endmodule

// File: rtl/pcap_seq.sv
module pcap_seq
  import pcap_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic          trig_in,
  input  logic [AW-1:0] pre_len,
  output logic          wr_en,
  output logic [AW-1:0] wr_ptr,
  output cap_state_t    state,
  output logic [AW-1:0] trig_addr,
  output logic [AW-1:0] win_start
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  cap_state_t    st_n;
  logic [AW-1:0] ptr_n, fill_q, fill_n, rem_q, rem_n, pre_q, pre_n;
  logic [AW-1:0] trig_n, win_n, post_init;
  logic          hist_full;

  assign hist_full = (fill_q == pre_q);
  assign post_init = LAST - pre_q;

  always_comb begin
    st_n   = state;
    ptr_n  = wr_ptr;
    fill_n = fill_q;
    rem_n  = rem_q;
    pre_n  = pre_q;
    trig_n = trig_addr;
    win_n  = win_start;
    wr_en  = 1'b0;
    if (arm) begin
      st_n   = ST_ARMED;
      ptr_n  = '0;
      fill_n = '0;
      pre_n  = pre_len;
    end else begin
      unique case (state)
        ST_ARMED: begin
          wr_en = 1'b1;
          ptr_n = wr_ptr + 1'b1;
          if (!hist_full) fill_n = fill_q + 1'b1;
          if (trig_in && hist_full) begin
            trig_n = wr_ptr;
            win_n  = wr_ptr - pre_q;
            rem_n  = post_init;
            st_n   = (post_init == '0) ? ST_DONE : ST_POST;
          end
        end
        ST_POST: begin
          wr_en = 1'b1;
          ptr_n = wr_ptr + 1'b1;
          rem_n = rem_q - 1'b1;
          if (rem_q == AW'(1)) st_n = ST_DONE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      wr_ptr    <= '0;
      fill_q    <= '0;
      rem_q     <= '0;
      pre_q     <= '0;
      trig_addr <= '0;
      win_start <= '0;
    end else begin
      state     <= st_n;
      wr_ptr    <= ptr_n;
      fill_q    <= fill_n;
      rem_q     <= rem_n;
      pre_q     <= pre_n;
      trig_addr <= trig_n;
      win_start <= win_n;
    end
  end

  // R2: arm restarts the writer at address zero
  a_r2_arm_restart: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (state == ST_ARMED && wr_ptr == '0));
  // R4: a trigger before the history is full leaves the block armed
  a_r4_trig_guard: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ARMED && !arm && trig_in && fill_q != pre_q) |=> state == ST_ARMED);
  // R6: no writes while idle or done
  a_r6_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE || state == ST_DONE) |-> !wr_en);
endmodule

// File: rtl/pretrig_capture.sv
module pretrig_capture
  import pcap_pkg::*;
#(
  parameter int W     = 16,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic [AW-1:0] pre_len,
  input  logic [W-1:0]  sample_in,
  input  logic          trig_in,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data,
  output logic          rd_valid,
  output logic [AW-1:0] wr_addr,
  output logic          armed,
  output logic          triggered,
  output logic          done,
  output logic [AW-1:0] trig_addr,
  output logic [AW-1:0] win_start
);
  cap_state_t st;
  logic       wr_en;

  pcap_seq #(.DEPTH(DEPTH)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm       (arm),
    .trig_in   (trig_in),
    .pre_len   (pre_len),
    .wr_en     (wr_en),
    .wr_ptr    (wr_addr),
    .state     (st),
    .trig_addr (trig_addr),
    .win_start (win_start)
  );

  pcap_ram #(.W(W), .DEPTH(DEPTH)) u_ram (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (sample_in),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
  );

  assign armed     = (st == ST_ARMED);
  assign triggered = (st == ST_POST);
  assign done      = (st == ST_DONE);

  // R6: status flags are mutually exclusive
  a_r6_one_state: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({armed, triggered, done}));
  // R5: post phase is entered only from an armed cycle with a trigger
  a_r5_trig_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(triggered) |-> $past(armed && trig_in));
  // R7: the ring closes exactly at the window start
  a_r7_window_closes: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> wr_addr == win_start);
endmodule

// File: tb/pretrig_capture_test.sv
module pretrig_capture_test;
  localparam int W = 16, DEPTH = 16, AW = 4;

  logic clk = 1'b0;
  logic rst_n, arm, trig_in, rd_en;
  logic [AW-1:0] pre_len, rd_addr;
  logic [W-1:0] sample_in;
  logic [W-1:0] rd_data;
  logic rd_valid, armed, triggered, done;
  logic [AW-1:0] wr_addr, trig_addr, win_start;

  always #2 clk = ~clk; // 250 MHz

  pretrig_capture #(.W(W), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .arm(arm), .pre_len(pre_len),
    .sample_in(sample_in), .trig_in(trig_in), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
    .wr_addr(wr_addr), .armed(armed), .triggered(triggered),
    .done(done), .trig_addr(trig_addr), .win_start(win_start)
  );

  int tests = 0, fails = 0;
  bit auto_rd = 1'b1;

  task automatic chk(string tag, string what, longint act, longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // behavioural reference: 0 idle, 1 armed, 2 post, 3 done
  int m_st, m_ptr, m_fill, m_rem, m_pre, m_trig, m_win;
  logic [W-1:0] m_mem [DEPTH];
  bit m_known [DEPTH];
  logic [W-1:0] m_rd;
  bit m_rd_valid, m_rd_known;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_ptr = 0; m_fill = 0; m_rem = 0; m_pre = 0;
      m_trig = 0; m_win = 0; m_rd_valid = 0; m_rd_known = 0;
      for (int i = 0; i < DEPTH; i++) m_known[i] = 0;
    end else begin
      m_rd_valid = rd_en;
      if (rd_en) begin
        m_rd = m_mem[rd_addr];       // old contents before this edge's write
        m_rd_known = m_known[rd_addr];
      end
      if (arm) begin
        m_st = 1; m_ptr = 0; m_fill = 0; m_pre = pre_len;  // R9 sampled here only
      end else if (m_st == 1) begin
        m_mem[m_ptr] = sample_in; m_known[m_ptr] = 1;
        if (trig_in && m_fill >= m_pre) begin
          m_trig = m_ptr;
          m_win  = (m_ptr - m_pre + DEPTH) % DEPTH;
          m_rem  = DEPTH - m_pre - 1;
          m_st   = (m_rem == 0) ? 3 : 2;
        end else if (m_fill < m_pre) m_fill++;
        m_ptr = (m_ptr + 1) % DEPTH;
      end else if (m_st == 2) begin
        m_mem[m_ptr] = sample_in; m_known[m_ptr] = 1;
        if (m_rem == 1) m_st = 3;
        m_rem--;
        m_ptr = (m_ptr + 1) % DEPTH;
      end
    end
  end

  task automatic cmp_all();
    chk("R2", "armed", armed, m_st == 1);
    chk("R5", "triggered", triggered, m_st == 2);
    chk("R6", "done", done, m_st == 3);
    chk("R3", "wr_addr", wr_addr, m_ptr);
    chk("R5", "trig_addr", trig_addr, m_trig);
    chk("R7", "win_start", win_start, m_win);
    chk("R8", "rd_valid", rd_valid, m_rd_valid);
    if (m_rd_valid && m_rd_known) chk("R8", "rd_data", rd_data, m_rd);
  endtask

  task automatic tick();
    sample_in = W'($urandom);
    if (auto_rd) begin
      rd_en = 1'($urandom);
      rd_addr = AW'($urandom);
    end
    @(posedge clk);
    @(negedge clk);
    cmp_all();
    arm = 1'b0;
    trig_in = 1'b0;
  endtask

  task automatic run_to_done(int limit);
    for (int i = 0; i < limit && !done; i++) tick();
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; arm = 0; trig_in = 0; rd_en = 0; rd_addr = '0;
    pre_len = '0; sample_in = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "flags", {armed, triggered, done, rd_valid}, 0);
    chk("R1", "addresses", {wr_addr, trig_addr, win_start}, 0);
    rst_n = 1'b1;
    tick();

    // R4: early triggers ignored, capture with pre_len 4 across a wrap
    pre_len = 4'd4; arm = 1; tick();
    chk("R2", "arm restart", {armed, wr_addr}, {1'b1, 4'd0});
    trig_in = 1; tick(); trig_in = 1; tick();
    chk("R4", "early trigger ignored", triggered, 0);
    repeat (20) tick();
    trig_in = 1; tick();
    chk("R5", "trigger accepted", triggered, 1);
    run_to_done(40);
    chk("R6", "done after window", done, 1);
    chk("R7", "window start", win_start, (trig_addr - 4'd4) & 4'hF);
    trig_in = 1; tick(); tick();
    chk("R6", "trigger ignored when done", {done, wr_addr}, {1'b1, win_start});

    // R8: drain ring in order after capture
    auto_rd = 0;
    for (int a = 0; a < DEPTH; a++) begin
      rd_en = 1; rd_addr = AW'(a); tick();
    end
    rd_en = 0; tick(); tick();
    auto_rd = 1;

    // R4 boundary: pre_len 0, trigger in first armed cycle
    pre_len = 4'd0; arm = 1; tick();
    trig_in = 1; tick();
    chk("R4", "zero history trigger", {triggered, trig_addr}, {1'b1, 4'd0});
    run_to_done(40);
    chk("R6", "full post window", {done, wr_addr}, {1'b1, 4'd0});

    // R6 boundary: pre_len DEPTH-1, done directly after trigger
    pre_len = 4'd15; arm = 1; tick();
    repeat (18) tick();
    trig_in = 1; tick();
    chk("R6", "no post phase", {triggered, done}, {1'b0, 1'b1});

    // R9: pre_len change after arm has no effect
    pre_len = 4'd6; arm = 1; tick();
    pre_len = 4'd1; tick(); tick();
    trig_in = 1; tick();
    chk("R9", "late pre_len ignored", triggered, 0);
    repeat (4) tick();
    trig_in = 1; tick();
    chk("R9", "window uses armed length", win_start, (trig_addr - 4'd6) & 4'hF);

    // R2: re-arm in the middle of the post phase
    repeat (3) tick();
    arm = 1; tick();
    chk("R2", "re-arm mid post", {armed, triggered, done, wr_addr}, {3'b100, 4'd0});
    repeat (5) tick();
    trig_in = 1; tick();
    run_to_done(40);
    repeat (8) tick();

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule